// File: doc/BRIEF.md
# Ring-Counter Keypad Scan Encoder

The block scans a square matrix of key switches and reports the position of a pressed key as a 6-bit code. A ring of eight stages circulates a single low bit. Each stage drives one row line, so only one row is pulled low at any moment. A closed switch joins its row to its column, and the block watches eight active-low column inputs for that closure. On every scan tick the low bit moves one row onward. When a closure is seen, the ring stops and holds on that row. The row index and the column index are then captured into a code register, and a single-cycle strobe goes with them.

The scan rate is set by the `tick_i` enable, which the surrounding logic derives from the system clock (about 5 kHz nominal). A second capture is allowed only after a tick has seen every column high again. Scanning then resumes from the row where the ring was held.

Top module: `kscan_encoder`

## Requirements
- R1: While reset is low, and just after it is released, `row_n_o` is 8'hFE (row line i is ring stage i, stage 0 low), `key_code_o` is 0 and `key_valid_o` is 0.
- R2: `row_n_o` has exactly one bit low at every clock edge. A ring pattern without exactly one low bit is replaced by the reset pattern on the next tick.
- R3: On a clock edge with `tick_i`=1 and `col_n_i`=8'hFF, the low row moves from row i to row i+1, and from row 7 back to row 0. Starting from row s, a key in row r is therefore captured on tick ((r-s) mod 8)+1.
- R4: On a clock edge with `tick_i`=1 and any bit of `col_n_i` low, `row_n_o` is held unchanged.
- R5: On clock edges with `tick_i`=0, `row_n_o` does not change.
- R6: `key_code_o` is {row[2:0], col[2:0]}: bits 5:3 hold the index of the low row, and bits 2:0 hold the lowest-numbered low column.
- R7: The code loads once per press, on the first tick that sees a closure. `key_valid_o` is 1 for exactly the one cycle after that edge. Otherwise the code holds its value.
- R8: After a capture there is no new capture until a tick has seen `col_n_i`=8'hFF. That same tick moves the ring on from the held row to the next row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Scan-advance enable, one cycle per scan step |
| col_n_i | input | 8 | Column sense lines, low when a closed key joins them to the low row |
| row_n_o | output | 8 | Row drive lines, exactly one low |
| key_code_o | output | 6 | Captured {row index, column index} |
| key_valid_o | output | 1 | One-cycle strobe when a new code is loaded |

## Verification
The checker tests every cycle that exactly one row is low and that the ring steps on free ticks, holds while a column is low and stays still without a tick. It also checks that the strobe lasts a single cycle, follows a tick that saw a closure, and is the only time the code changes. Only the bench scenarios can show that the captured code holds the right row and column. The same goes for the lowest column winning among several, the latency from each start row, the rule that a key held across release-free ticks gives one capture only, and that scanning resumes from the held row.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  localparam int unsigned KS_ROWS = 8;
  localparam int unsigned KS_COLS = 8;
endpackage

// File: rtl/kscan_prio_enc.sv
// Lowest-index set bit wins.
module kscan_prio_enc #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/kscan_ring.sv
module kscan_ring #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         hold_i,
  output logic [N-1:0] ring_o,
  output logic         ok_o
);
  localparam logic [N-1:0] ONE     = N'(1);
  localparam logic [N-1:0] RST_PAT = ~ONE;

  logic [N-1:0] ring_q, ring_d;
  int unsigned  zcnt;

  always_comb begin
    zcnt = 0;
    for (int i = 0; i < N; i++) begin
      if (!ring_q[i]) zcnt++;
    end
  end
  assign ok_o = (zcnt == 1);

  always_comb begin
    ring_d = ring_q;
    if (tick_i) begin
      if (!ok_o)        ring_d = RST_PAT;
      else if (!hold_i) ring_d = {ring_q[N-2:0], ring_q[N-1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ring_q <= RST_PAT;
    else         ring_q <= ring_d;
  end

  assign ring_o = ring_q;
endmodule

// File: rtl/kscan_capture.sv
module kscan_capture #(
  parameter int unsigned RW = 3,
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          hit_i,
  input  logic          ok_i,
  input  logic [RW-1:0] row_idx_i,
  input  logic [CW-1:0] col_idx_i,
  output logic [RW+CW-1:0] code_o,
  output logic          valid_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= '0;
      valid_o <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) begin
        if (hit_i && armed_q && ok_i) begin
          code_o  <= {row_idx_i, col_idx_i};
          valid_o <= 1'b1;
          armed_q <= 1'b0;
        end else if (!hit_i) begin
          armed_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kscan_encoder.sv
module kscan_encoder
  import kscan_pkg::*;
#(
  parameter int unsigned N_ROWS = KS_ROWS,
  parameter int unsigned N_COLS = KS_COLS,
  localparam int unsigned RW = $clog2(N_ROWS),
  localparam int unsigned CW = $clog2(N_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [N_COLS-1:0] col_n_i,
  output logic [N_ROWS-1:0] row_n_o,
  output logic [RW+CW-1:0]  key_code_o,
  output logic              key_valid_o
);
  logic [N_ROWS-1:0] ring;
  logic              ring_ok, hit, row_any;
  logic [RW-1:0]     row_idx;
  logic [CW-1:0]     col_idx;

  kscan_ring #(.N(N_ROWS)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .hold_i (hit),
    .ring_o (ring),
    .ok_o   (ring_ok)
  );

  kscan_prio_enc #(.N(N_ROWS)) u_row_enc (
    .req_i (~ring),
    .idx_o (row_idx),
    .any_o (row_any)
  );

  kscan_prio_enc #(.N(N_COLS)) u_col_enc (
    .req_i (~col_n_i),
    .idx_o (col_idx),
    .any_o (hit)
  );

  kscan_capture #(.RW(RW), .CW(CW)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .hit_i     (hit),
    .ok_i      (ring_ok & row_any),
    .row_idx_i (row_idx),
    .col_idx_i (col_idx),
    .code_o    (key_code_o),
    .valid_o   (key_valid_o)
  );

  assign row_n_o = ring;
endmodule

// File: rtl/kscan_checker.sv
module kscan_checker #(
  parameter int unsigned N_ROWS = 8,
  parameter int unsigned N_COLS = 8,
  parameter int unsigned CODE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [N_COLS-1:0] col_n_i,
  input logic [N_ROWS-1:0] row_n_o,
  input logic [CODE_W-1:0] key_code_o,
  input logic              key_valid_o
);
  a_r2_one_row_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~row_n_o) == 1);

  a_r3_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (&col_n_i)) |=>
      row_n_o == {$past(row_n_o[N_ROWS-2:0]), $past(row_n_o[N_ROWS-1])});

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(&col_n_i)) |=> $stable(row_n_o));

  a_r5_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(row_n_o));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |=> !key_valid_o);

  a_r7_code_only_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_valid_o |-> $stable(key_code_o));

  a_r8_valid_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> ($past(tick_i) && !(&$past(col_n_i))));
endmodule

bind kscan_encoder kscan_checker #(
  .N_ROWS (N_ROWS),
  .N_COLS (N_COLS),
  .CODE_W (RW + CW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .col_n_i     (col_n_i),
  .row_n_o     (row_n_o),
  .key_code_o  (key_code_o),
  .key_valid_o (key_valid_o)
);

// File: tb/sim_kscan_encoder.sv
`timescale 1ns/1ps
module sim_kscan_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] col_n;
  logic [7:0] row_n;
  logic [5:0] code;
  logic       valid;
  logic [7:0] press [8];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kscan_encoder u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .col_n_i     (col_n),
    .row_n_o     (row_n),
    .key_code_o  (code),
    .key_valid_o (valid)
  );

  // switch matrix model
  always_comb begin
    col_n = 8'hFF;
    for (int r = 0; r < 8; r++) begin
      if (!row_n[r]) col_n = col_n & ~press[r];
    end
  end

  // {row, pressed column mask, expected code}
  localparam logic [16:0] VEC [6] = '{
    {3'd3, 8'b0000_0100, 6'b011_010},
    {3'd0, 8'b1000_0000, 6'b000_111},
    {3'd7, 8'b0010_0100, 6'b111_010},
    {3'd5, 8'b0100_0001, 6'b101_000},
    {3'd1, 8'b0000_0010, 6'b001_001},
    {3'd6, 8'b0001_0000, 6'b110_100}
  };

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_keys();
    for (int r = 0; r < 8; r++) press[r] = 8'h00;
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  function automatic logic [7:0] row_pat(int r);
    return ~(8'h01 << r);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s;
    clear_keys();
    repeat (3) @(negedge clk);
    check("R1 reset row", int'(row_n), 8'hFE);
    check("R1 reset code", int'(code), 0);
    check("R1 reset valid", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release row", int'(row_n), 8'hFE);
    s = 0;

    // R5: no movement without tick
    repeat (10) @(negedge clk);
    check("R5 idle row", int'(row_n), 8'hFE);

    foreach (VEC[k]) begin
      int r, n, exp_n;
      bit got;
      logic [5:0] ecode;
      logic [7:0] held;
      r     = int'(VEC[k][16:14]);
      ecode = VEC[k][5:0];
      clear_keys();
      press[r] = VEC[k][13:6];
      exp_n = ((r - s + 8) % 8) + 1;
      n = 0;
      got = 0;
      while (!got && n < 9) begin
        do_tick();
        n++;
        check("R2 one row low", $countones(~row_n), 1);
        if (valid) got = 1;
      end
      check("R7 capture seen", int'(got), 1);
      check("R3 capture latency", n, exp_n);
      check("R6 key code", int'(code), int'(ecode));
      check("R4 ring held on row", int'(row_n), int'(row_pat(r)));
      @(negedge clk);
      check("R7 valid one cycle", int'(valid), 0);
      held = row_n;
      for (int t = 0; t < 3; t++) begin
        do_tick();
        check("R7 no second capture", int'(valid), 0);
        check("R4 held while pressed", int'(row_n), int'(held));
      end
      check("R7 code holds", int'(code), int'(ecode));
      clear_keys();
      do_tick();
      check("R8 resume from held row", int'(row_n), int'(row_pat((r + 1) % 8)));
      check("R8 no valid on release", int'(valid), 0);
      s = (r + 1) % 8;
    end

    // R8: repress before any all-high tick gives no capture
    clear_keys();
    press[s] = 8'b0000_1000;
    do_tick();
    check("R8 first capture", int'(valid), 1);
    check("R6 code col 3", int'(code), (s << 3) | 3);
    clear_keys();
    repeat (2) @(negedge clk);
    press[s] = 8'b0000_0001;
    do_tick();
    check("R8 no rearm without tick release", int'(valid), 0);
    check("R8 code unchanged", int'(code), (s << 3) | 3);
    check("R4 still held", int'(row_n), int'(row_pat(s)));
    clear_keys();
    do_tick();
    s = (s + 1) % 8;
    check("R8 advance after release", int'(row_n), int'(row_pat(s)));

    // R3: full lap with no keys returns to the same row
    for (int t = 0; t < 8; t++) do_tick();
    check("R3 full lap", int'(row_n), int'(row_pat(s)));

    // R1: reset mid-scan
    do_tick();
    do_tick();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-scan reset row", int'(row_n), 8'hFE);
    check("R1 mid-scan reset code", int'(code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_tick();
    check("R3 first step after reset", int'(row_n), 8'hFD);

    finish_run();
  end
endmodule